// File: doc/BRIEF.md
# Extension Operation Unit

This unit executes the small parallel operation carried in the low byte of a 16-bit instruction word, next to the main operation that owns the upper byte. It decodes that byte into three things: data-memory traffic (at most one store and one load), commands that step the address pointers, and register write-back requests. Main-operation execution and program sequencing belong to other units. The extension never changes program flow.

Execution has two phases. In the issue cycle the unit samples the byte together with snapshots of the accumulator words, pointers and index values. One cycle later it drives the memory request and the pointer-update commands. A load's data returns from the memory one cycle after the request and is held inside the unit. Write-backs are issued only when the main-operation stage raises the epilogue strobe. This lets the main operation read register values from before the extension. The pointer-update commands carry the new pointer value: a plain increment, or the pointer plus its index value.

The environment lets the epilogue of one extension come no earlier than three cycles after its issue. It issues the next extension no earlier than that epilogue cycle.

Top module: `xop_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `mem_we`, `mem_re`, `ptr_upd_en`, `wb0_en` and `wb1_en` are all 0, whatever the other inputs are.
- R2: The following bytes cause no memory access, no pointer update and no write-back: byte 0x00, any byte whose top nibble is 0000, and any byte of the form 11xx_xx11.
- R3: Byte 0001_ddss (copy) requests a write-back to destination code {0,dd}. The value is accumulator source word ss as sampled at issue. The copy makes no memory access.
- R4: Byte 001a_apqq (store) writes accumulator source word aa to the address in pointer qq, one cycle after issue. Pointer qq then steps: by +1 when p=0, or by adding its index when p=1.
- R5: Byte 01kk_kpqq (load) reads the address in pointer qq, one cycle after issue. The returned word is written back to destination code kkk. Destination codes: 0 aux0 low, 1 aux1 low, 2 aux0 high, 3 aux1 high, 4 to 7 accumulator words. Pointer qq steps as in R4.
- R6: Byte 10kk_xyfs is a paired store and load. The store data is accumulator middle word s. With f=0 the store goes to pointer 3 and the load comes from pointer 0. With f=1 the store goes to pointer 0 and the load comes from pointer 3. The loaded word goes to destination code {0,kk}.
- R7: For 10kk_xyfs, bit 2 (y) makes pointer 0 add its index instead of +1, and bit 3 (x) does the same for pointer 3. Both pointers are updated.
- R8: Byte 11ab_xyqq with qq≠3 reads pointer qq once. The same word is written back to destination codes {0,a,0} and {0,b,1}. Pointer qq steps by index when y=1 (else +1), and pointer 3 steps by index when x=1 (else +1).
- R9: Write-back enables are high only in a cycle where `epi_stb` is high, once per extension, and never before the epilogue.
- R10: Pointer updates form a single-cycle pulse, one cycle after issue. Their values are computed from the pointer and index snapshot taken at issue, modulo 2^ADDR_W.
- R11: Each memory request is a single-cycle pulse, one cycle after issue, with at most one write and one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xop_valid | input | 1 | Issue strobe for the extension byte |
| xop_byte | input | 8 | Extension byte |
| epi_stb | input | 1 | Epilogue strobe from the main-operation stage |
| acc_lo_i | input | 4×DATA_W | Accumulator source words 0..3 (copy and store data) |
| acc_mid_i | input | 2×DATA_W | Accumulator middle words 0..1 (paired store data) |
| ptr_i | input | 4×ADDR_W | Address pointers 0..3 |
| idx_i | input | 4×ADDR_W | Index values paired with the pointers |
| mem_we | output | 1 | Memory write pulse |
| mem_waddr | output | ADDR_W | Write address |
| mem_wdata | output | DATA_W | Write data |
| mem_re | output | 1 | Memory read pulse; data is expected one cycle later |
| mem_raddr | output | ADDR_W | Read address |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_re` |
| ptr_upd_en | output | 4 | Per-pointer update pulse |
| ptr_upd_val | output | 4×ADDR_W | New pointer values |
| wb0_en | output | 1 | First write-back request |
| wb0_dst | output | 3 | First destination code |
| wb1_en | output | 1 | Second write-back request (dual load only) |
| wb1_dst | output | 3 | Second destination code |
| wb_data | output | DATA_W | Write-back value |

## Verification
The bench aims at five behaviours.

- **Paired forms in both directions.** A design that swapped pointer 0 and pointer 3 would store and load at the wrong addresses.
- **Independent index bits.** Each pointer of a paired or dual form has its own index bit. Mixing them up would step the wrong pointer by its index.
- **Dual-load destinations.** If the two destination codes were built wrongly, the load would overwrite the wrong auxiliary halves.
- **Snapshot timing.** The bench scrambles every register input right after issue and holds the epilogue back for a varying time. A design that read live inputs, or released write-backs early, would then miscompare.
- **Edge encodings.** Pointer wrap at the top of the address space and negative index steps catch width mistakes. The 11xx_xx11 holes must stay silent.

// File: rtl/xop_pkg.sv
// Shared types for the extension operation unit.
// Assumes four pointers and a one-byte extension field.
package xop_pkg;
    localparam int NUM_PTR    = 4;
    localparam int NUM_ACC_LO = 4;
    localparam int NUM_ACC_MD = 2;
    localparam int DST_W      = 3;
    localparam int XOP_W      = 8;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_IDX  = 2'd2
    } step_e;

    typedef struct packed {
        logic                     wr_en;
        logic                     wr_mid;
        logic [1:0]               wr_sel;
        logic [1:0]               wr_ptr;
        logic                     rd_en;
        logic [1:0]               rd_ptr;
        logic                     mv_en;
        logic [1:0]               mv_sel;
        logic                     wb0_en;
        logic [DST_W-1:0]         wb0_dst;
        logic                     wb1_en;
        logic [DST_W-1:0]         wb1_dst;
        step_e [NUM_PTR-1:0]      step;
    } xop_dec_t;
endpackage

// File: rtl/xop_decode.sv
// Combinational decoder: turns the extension byte into memory, pointer
// and write-back controls. Assumes nothing about the main operation.
module xop_decode
    import xop_pkg::*;
(
    input  logic [XOP_W-1:0] byte_i,
    output xop_dec_t         dec_o
);
    // Decode one byte into the control bundle
    always_comb begin
        dec_o = '0;
        for (int i = 0; i < NUM_PTR; i++) dec_o.step[i] = STEP_HOLD;
        unique case (byte_i[7:6])
            2'b00: begin
                if (byte_i[5:4] == 2'b01) begin
                    dec_o.mv_en   = 1'b1;
                    dec_o.mv_sel  = byte_i[1:0];
                    dec_o.wb0_en  = 1'b1;
                    dec_o.wb0_dst = {1'b0, byte_i[3:2]};
                end else if (byte_i[5]) begin
                    dec_o.wr_en  = 1'b1;
                    dec_o.wr_sel = byte_i[4:3];
                    dec_o.wr_ptr = byte_i[1:0];
                    dec_o.step[byte_i[1:0]] = byte_i[2] ? STEP_IDX : STEP_INC;
                end
            end
            2'b01: begin
                dec_o.rd_en   = 1'b1;
                dec_o.rd_ptr  = byte_i[1:0];
                dec_o.wb0_en  = 1'b1;
                dec_o.wb0_dst = byte_i[5:3];
                dec_o.step[byte_i[1:0]] = byte_i[2] ? STEP_IDX : STEP_INC;
            end
            2'b10: begin
                dec_o.wr_en   = 1'b1;
                dec_o.wr_mid  = 1'b1;
                dec_o.wr_sel  = {1'b0, byte_i[0]};
                dec_o.wr_ptr  = byte_i[1] ? 2'd0 : 2'd3;
                dec_o.rd_en   = 1'b1;
                dec_o.rd_ptr  = byte_i[1] ? 2'd3 : 2'd0;
                dec_o.wb0_en  = 1'b1;
                dec_o.wb0_dst = {1'b0, byte_i[5:4]};
                dec_o.step[0] = byte_i[2] ? STEP_IDX : STEP_INC;
                dec_o.step[3] = byte_i[3] ? STEP_IDX : STEP_INC;
            end
            default: begin
                if (byte_i[1:0] != 2'd3) begin
                    dec_o.rd_en   = 1'b1;
                    dec_o.rd_ptr  = byte_i[1:0];
                    dec_o.wb0_en  = 1'b1;
                    dec_o.wb0_dst = {1'b0, byte_i[5], 1'b0};
                    dec_o.wb1_en  = 1'b1;
                    dec_o.wb1_dst = {1'b0, byte_i[4], 1'b1};
                    dec_o.step[byte_i[1:0]] = byte_i[2] ? STEP_IDX : STEP_INC;
                    dec_o.step[3] = byte_i[3] ? STEP_IDX : STEP_INC;
                end
            end
        endcase
    end
endmodule

// File: rtl/xop_ptr_step.sv
// Per-pointer next-value arithmetic, one lane per pointer.
// Assumes plain modular arithmetic; any wrap policy lives in the address unit.
module xop_ptr_step
    import xop_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  step_e [NUM_PTR-1:0]              step_i,
    input  logic  [NUM_PTR-1:0][ADDR_W-1:0]  ptr_i,
    input  logic  [NUM_PTR-1:0][ADDR_W-1:0]  idx_i,
    output logic  [NUM_PTR-1:0]              en_o,
    output logic  [NUM_PTR-1:0][ADDR_W-1:0]  val_o
);
    for (genvar g = 0; g < NUM_PTR; g++) begin : g_lane
        // Lane enable and new value for pointer g
        assign en_o[g]  = (step_i[g] != STEP_HOLD);
        assign val_o[g] = (step_i[g] == STEP_IDX) ? ptr_i[g] + idx_i[g]
                                                  : ptr_i[g] + ADDR_W'(1);
    end
endmodule

// File: rtl/xop_mem_req.sv
// Registers the single-cycle memory request one cycle after issue.
// Assumes the memory returns read data one cycle after the read pulse.
module xop_mem_req
    import xop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                issue_i,
    input  logic                                wr_en_i,
    input  logic                                wr_mid_i,
    input  logic [1:0]                          wr_sel_i,
    input  logic [1:0]                          wr_ptr_i,
    input  logic                                rd_en_i,
    input  logic [1:0]                          rd_ptr_i,
    input  logic [NUM_ACC_LO-1:0][DATA_W-1:0]   acc_lo_i,
    input  logic [NUM_ACC_MD-1:0][DATA_W-1:0]   acc_mid_i,
    input  logic [NUM_PTR-1:0][ADDR_W-1:0]      ptr_i,
    output logic                                we_o,
    output logic [ADDR_W-1:0]                   waddr_o,
    output logic [DATA_W-1:0]                   wdata_o,
    output logic                                re_o,
    output logic [ADDR_W-1:0]                   raddr_o
);
    // Request strobes, one pulse per issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_o <= 1'b0;
            re_o <= 1'b0;
        end else begin
            we_o <= issue_i & wr_en_i;
            re_o <= issue_i & rd_en_i;
        end
    end

    // Address and data capture from the issue snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr_o <= '0;
            wdata_o <= '0;
            raddr_o <= '0;
        end else begin
            if (issue_i && wr_en_i) begin
                waddr_o <= ptr_i[wr_ptr_i];
                wdata_o <= wr_mid_i ? acc_mid_i[wr_sel_i[0]] : acc_lo_i[wr_sel_i];
            end
            if (issue_i && rd_en_i)
                raddr_o <= ptr_i[rd_ptr_i];
        end
    end
endmodule

// File: rtl/xop_wb_hold.sv
// Holds the write-back value and destinations until the epilogue strobe.
// Assumes the epilogue comes at least three cycles after issue and
// that the next issue comes no earlier than the epilogue.
module xop_wb_hold
    import xop_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_i,
    input  logic               rd_en_i,
    input  logic               mv_en_i,
    input  logic [DATA_W-1:0]  mv_val_i,
    input  logic               wb0_en_i,
    input  logic [DST_W-1:0]   wb0_dst_i,
    input  logic               wb1_en_i,
    input  logic [DST_W-1:0]   wb1_dst_i,
    input  logic [DATA_W-1:0]  rdata_i,
    input  logic               epi_i,
    output logic               wb0_en_o,
    output logic [DST_W-1:0]   wb0_dst_o,
    output logic               wb1_en_o,
    output logic [DST_W-1:0]   wb1_dst_o,
    output logic [DATA_W-1:0]  wb_data_o
);
    logic armed_q, ready_q, cap1_q, cap2_q, w0_q, w1_q;
    logic [DST_W-1:0]  d0_q, d1_q;
    logic [DATA_W-1:0] hold_q;

    // Track pending write-back and the read-return window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            ready_q <= 1'b0;
            cap1_q  <= 1'b0;
            cap2_q  <= 1'b0;
        end else begin
            cap1_q <= issue_i & rd_en_i;
            cap2_q <= cap1_q;
            if (epi_i)  armed_q <= 1'b0;
            if (cap2_q) ready_q <= 1'b1;
            if (issue_i) begin
                armed_q <= wb0_en_i | wb1_en_i;
                ready_q <= mv_en_i;
            end
        end
    end

    // Capture destinations and the value to be written back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w0_q   <= 1'b0;
            w1_q   <= 1'b0;
            d0_q   <= '0;
            d1_q   <= '0;
            hold_q <= '0;
        end else begin
            if (issue_i) begin
                w0_q <= wb0_en_i;
                w1_q <= wb1_en_i;
                d0_q <= wb0_dst_i;
                d1_q <= wb1_dst_i;
                if (mv_en_i) hold_q <= mv_val_i;
            end
            if (cap2_q) hold_q <= rdata_i;
        end
    end

    // Release the write-back in the epilogue cycle only
    assign wb0_en_o  = epi_i & armed_q & ready_q & w0_q;
    assign wb1_en_o  = epi_i & armed_q & ready_q & w1_q;
    assign wb0_dst_o = d0_q;
    assign wb1_dst_o = d1_q;
    assign wb_data_o = hold_q;
endmodule

// File: rtl/xop_unit.sv
// Extension operation unit top: decodes the extension byte, issues the
// memory request and pointer updates one cycle after issue, and defers
// register write-back to the epilogue strobe.
module xop_unit
    import xop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                xop_valid,
    input  logic [XOP_W-1:0]                    xop_byte,
    input  logic                                epi_stb,
    input  logic [NUM_ACC_LO-1:0][DATA_W-1:0]   acc_lo_i,
    input  logic [NUM_ACC_MD-1:0][DATA_W-1:0]   acc_mid_i,
    input  logic [NUM_PTR-1:0][ADDR_W-1:0]      ptr_i,
    input  logic [NUM_PTR-1:0][ADDR_W-1:0]      idx_i,
    output logic                                mem_we,
    output logic [ADDR_W-1:0]                   mem_waddr,
    output logic [DATA_W-1:0]                   mem_wdata,
    output logic                                mem_re,
    output logic [ADDR_W-1:0]                   mem_raddr,
    input  logic [DATA_W-1:0]                   mem_rdata,
    output logic [NUM_PTR-1:0]                  ptr_upd_en,
    output logic [NUM_PTR-1:0][ADDR_W-1:0]      ptr_upd_val,
    output logic                                wb0_en,
    output logic [DST_W-1:0]                    wb0_dst,
    output logic                                wb1_en,
    output logic [DST_W-1:0]                    wb1_dst,
    output logic [DATA_W-1:0]                   wb_data
);
    xop_dec_t                       dec;
    logic [NUM_PTR-1:0]             step_en;
    logic [NUM_PTR-1:0][ADDR_W-1:0] step_val;

    xop_decode u_dec (
        .byte_i (xop_byte),
        .dec_o  (dec)
    );

    xop_ptr_step #(.ADDR_W(ADDR_W)) u_step (
        .step_i (dec.step),
        .ptr_i  (ptr_i),
        .idx_i  (idx_i),
        .en_o   (step_en),
        .val_o  (step_val)
    );

    xop_mem_req #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_i   (xop_valid),
        .wr_en_i   (dec.wr_en),
        .wr_mid_i  (dec.wr_mid),
        .wr_sel_i  (dec.wr_sel),
        .wr_ptr_i  (dec.wr_ptr),
        .rd_en_i   (dec.rd_en),
        .rd_ptr_i  (dec.rd_ptr),
        .acc_lo_i  (acc_lo_i),
        .acc_mid_i (acc_mid_i),
        .ptr_i     (ptr_i),
        .we_o      (mem_we),
        .waddr_o   (mem_waddr),
        .wdata_o   (mem_wdata),
        .re_o      (mem_re),
        .raddr_o   (mem_raddr)
    );

    xop_wb_hold #(.DATA_W(DATA_W)) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_i   (xop_valid),
        .rd_en_i   (dec.rd_en),
        .mv_en_i   (dec.mv_en),
        .mv_val_i  (acc_lo_i[dec.mv_sel]),
        .wb0_en_i  (dec.wb0_en),
        .wb0_dst_i (dec.wb0_dst),
        .wb1_en_i  (dec.wb1_en),
        .wb1_dst_i (dec.wb1_dst),
        .rdata_i   (mem_rdata),
        .epi_i     (epi_stb),
        .wb0_en_o  (wb0_en),
        .wb0_dst_o (wb0_dst),
        .wb1_en_o  (wb1_en),
        .wb1_dst_o (wb1_dst),
        .wb_data_o (wb_data)
    );

    // Pointer update pulse and values, registered one cycle after issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_upd_en  <= '0;
            ptr_upd_val <= '0;
        end else begin
            ptr_upd_en <= xop_valid ? step_en : '0;
            if (xop_valid) ptr_upd_val <= step_val;
        end
    end
endmodule

// File: rtl/xop_unit_chk.sv
// Property checker for xop_unit, attached by bind below.
module xop_unit_chk
    import xop_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            xop_valid,
    input logic [XOP_W-1:0]                xop_byte,
    input logic                            epi_stb,
    input logic [NUM_PTR-1:0][ADDR_W-1:0]  ptr_i,
    input logic                            mem_we,
    input logic [ADDR_W-1:0]               mem_waddr,
    input logic                            mem_re,
    input logic [NUM_PTR-1:0]              ptr_upd_en,
    input logic                            wb0_en,
    input logic                            wb1_en
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!mem_we && !mem_re && ptr_upd_en == '0));

    assert_zero_byte_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xop_valid && xop_byte == 8'h00) |=> (!mem_we && !mem_re && ptr_upd_en == '0));

    assert_copy_no_memory_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xop_valid && xop_byte[7:4] == 4'b0001) |=> (!mem_we && !mem_re));

    assert_store_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xop_valid && xop_byte[7:5] == 3'b001) |=>
            (mem_we && !mem_re && mem_waddr == $past(ptr_i[xop_byte[1:0]])
             && ptr_upd_en == (4'd1 << $past(xop_byte[1:0]))));

    assert_dual_pairs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb1_en |-> wb0_en);

    assert_wb_at_epilogue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb0_en || wb1_en) |-> epi_stb);

    assert_ptr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_upd_en != '0) |-> $past(xop_valid));

    assert_mem_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> $past(xop_valid));
endmodule

bind xop_unit xop_unit_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/xop_unit_tb_top.sv
module xop_unit_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              xop_valid = 1'b0;
    logic [7:0]        xop_byte = 8'h00;
    logic              epi_stb = 1'b0;
    logic [3:0][15:0]  acc_lo = '0;
    logic [1:0][15:0]  acc_mid = '0;
    logic [3:0][15:0]  ptr = '0;
    logic [3:0][15:0]  idx = '0;
    logic              mem_we, mem_re;
    logic [15:0]       mem_waddr, mem_wdata, mem_raddr;
    logic [15:0]       mem_rdata = '0;
    logic [3:0]        ptr_upd_en;
    logic [3:0][15:0]  ptr_upd_val;
    logic              wb0_en, wb1_en;
    logic [2:0]        wb0_dst, wb1_dst;
    logic [15:0]       wb_data;

    xop_unit dut_i (
        .clk(clk), .rst_n(rst_n), .xop_valid(xop_valid), .xop_byte(xop_byte),
        .epi_stb(epi_stb), .acc_lo_i(acc_lo), .acc_mid_i(acc_mid), .ptr_i(ptr),
        .idx_i(idx), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .ptr_upd_en(ptr_upd_en), .ptr_upd_val(ptr_upd_val), .wb0_en(wb0_en),
        .wb0_dst(wb0_dst), .wb1_en(wb1_en), .wb1_dst(wb1_dst), .wb_data(wb_data)
    );

    // Environment memory, one-cycle read latency
    logic [15:0] tbmem [0:65535];
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= tbmem[mem_raddr];
        if (mem_we) tbmem[mem_waddr] <= mem_wdata;
    end

    int nvec = 0;
    int nfail = 0;

    // Reference expectations
    logic             e_we, e_re, e_w0, e_w1;
    logic [15:0]      e_waddr, e_wdata, e_raddr, e_data;
    logic [2:0]       e_d0, e_d1;
    logic [3:0]       e_pen;
    logic [3:0][15:0] e_pval;

    task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [15:0] stepped(int i, logic use_idx);
        return use_idx ? 16'(ptr[i] + idx[i]) : 16'(ptr[i] + 16'd1);
    endfunction

    task automatic set_regs(int seed);
        for (int i = 0; i < 4; i++) begin
            acc_lo[i] = 16'(16'h1111 * (i + 1) + seed);
            ptr[i]    = 16'(16'h2000 * (i + 1) + seed * 3);
            idx[i]    = 16'(16'h0010 * (i + 1) + seed);
        end
        acc_mid[0] = 16'(16'hA0A0 + seed);
        acc_mid[1] = 16'(16'hB0B0 + seed);
    endtask

    // Behavioural model of one extension byte
    task automatic predict(logic [7:0] b);
        int sp, lp, q;
        e_we = 0; e_re = 0; e_w0 = 0; e_w1 = 0; e_pen = '0; e_pval = '0;
        e_waddr = '0; e_wdata = '0; e_raddr = '0; e_data = '0; e_d0 = '0; e_d1 = '0;
        q = int'(b[1:0]);
        if (b[7:4] == 4'b0001) begin
            e_w0 = 1; e_d0 = {1'b0, b[3:2]}; e_data = acc_lo[q];
        end else if (b[7:5] == 3'b001) begin
            e_we = 1; e_waddr = ptr[q]; e_wdata = acc_lo[b[4:3]];
            e_pen[q] = 1; e_pval[q] = stepped(q, b[2]);
        end else if (b[7:6] == 2'b01) begin
            e_re = 1; e_raddr = ptr[q]; e_w0 = 1; e_d0 = b[5:3];
            e_data = tbmem[ptr[q]]; e_pen[q] = 1; e_pval[q] = stepped(q, b[2]);
        end else if (b[7:6] == 2'b10) begin
            sp = b[1] ? 0 : 3; lp = b[1] ? 3 : 0;
            e_we = 1; e_waddr = ptr[sp]; e_wdata = acc_mid[b[0]];
            e_re = 1; e_raddr = ptr[lp]; e_w0 = 1; e_d0 = {1'b0, b[5:4]};
            e_data = tbmem[ptr[lp]];
            e_pen[0] = 1; e_pval[0] = stepped(0, b[2]);
            e_pen[3] = 1; e_pval[3] = stepped(3, b[3]);
        end else if (b[7:6] == 2'b11 && q != 3) begin
            e_re = 1; e_raddr = ptr[q]; e_data = tbmem[ptr[q]];
            e_w0 = 1; e_d0 = {1'b0, b[5], 1'b0};
            e_w1 = 1; e_d1 = {1'b0, b[4], 1'b1};
            e_pen[q] = 1; e_pval[q] = stepped(q, b[2]);
            e_pen[3] = 1; e_pval[3] = stepped(3, b[3]);
        end
    endtask

    task automatic quiet(string tag);
        chk(tag, "mem_we", 64'(mem_we), 64'd0);
        chk(tag, "mem_re", 64'(mem_re), 64'd0);
        chk(tag, "ptr_upd_en", 64'(ptr_upd_en), 64'd0);
        chk("R9", "wb0_en", 64'(wb0_en), 64'd0);
        chk("R9", "wb1_en", 64'(wb1_en), 64'd0);
    endtask

    // Issue one byte, then compare every cycle up to one past the epilogue
    task automatic do_op(logic [7:0] b, int gap, string tag);
        @(negedge clk);
        xop_valid = 1; xop_byte = b; predict(b);
        #1 quiet("R11");
        @(negedge clk);
        xop_valid = 0;
        acc_lo = ~acc_lo; acc_mid = ~acc_mid; ptr = ptr ^ {4{16'h0F0F}}; idx = ~idx;
        #1;
        chk(tag, "mem_we", 64'(mem_we), 64'(e_we));
        chk(tag, "mem_re", 64'(mem_re), 64'(e_re));
        if (e_we) begin
            chk(tag, "mem_waddr", 64'(mem_waddr), 64'(e_waddr));
            chk(tag, "mem_wdata", 64'(mem_wdata), 64'(e_wdata));
        end
        if (e_re) chk(tag, "mem_raddr", 64'(mem_raddr), 64'(e_raddr));
        chk(tag, "ptr_upd_en", 64'(ptr_upd_en), 64'(e_pen));
        for (int i = 0; i < 4; i++)
            if (e_pen[i]) chk(tag, "ptr_upd_val", 64'(ptr_upd_val[i]), 64'(e_pval[i]));
        chk("R9", "wb0_en early", 64'(wb0_en), 64'd0);
        @(negedge clk); #1 quiet("R11");
        for (int g = 0; g < gap; g++) begin
            @(negedge clk); #1 quiet("R10");
        end
        @(negedge clk);
        epi_stb = 1;
        #1;
        chk(tag, "wb0_en", 64'(wb0_en), 64'(e_w0));
        chk(tag, "wb1_en", 64'(wb1_en), 64'(e_w1));
        if (e_w0) begin
            chk(tag, "wb0_dst", 64'(wb0_dst), 64'(e_d0));
            chk(tag, "wb_data", 64'(wb_data), 64'(e_data));
        end
        if (e_w1) chk(tag, "wb1_dst", 64'(wb1_dst), 64'(e_d1));
        @(negedge clk);
        epi_stb = 0;
        #1 quiet("R9");
    endtask

    initial begin
        #(200000 * 10);
        nfail++;
        $display("FAIL R9 watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 65536; a++) tbmem[a] = 16'((a * 7) ^ 16'h5A3C);
        set_regs(1);
        // R1: reset dominates a valid store byte
        xop_valid = 1; xop_byte = 8'h21;
        repeat (3) begin
            @(negedge clk); #1;
            chk("R1", "mem_we", 64'(mem_we), 64'd0);
            chk("R1", "mem_re", 64'(mem_re), 64'd0);
            chk("R1", "ptr_upd_en", 64'(ptr_upd_en), 64'd0);
            chk("R1", "wb0_en", 64'(wb0_en), 64'd0);
        end
        @(negedge clk);
        xop_valid = 0; rst_n = 1;
        #1 quiet("R1");

        set_regs(2);  do_op(8'h00, 0, "R2");
        set_regs(3);  do_op(8'h05, 0, "R2");
        set_regs(4);  do_op(8'h0E, 1, "R2");
        set_regs(5);  do_op(8'hC3, 0, "R2");
        set_regs(6);  do_op(8'hF7, 0, "R2");
        set_regs(7);  do_op(8'h1B, 0, "R3");
        set_regs(8);  do_op(8'h14, 2, "R3");
        set_regs(9);  do_op(8'h21, 0, "R4");
        set_regs(10); do_op(8'h3E, 0, "R4");
        set_regs(11); do_op(8'h42, 0, "R5");
        set_regs(12); do_op(8'h7D, 3, "R5");
        set_regs(13); do_op(8'h90, 0, "R6");
        set_regs(14); do_op(8'hA3, 0, "R6");
        set_regs(15); do_op(8'h8C, 0, "R7");
        set_regs(16); do_op(8'hB6, 1, "R7");
        set_regs(17); do_op(8'hE4, 0, "R8");
        set_regs(18); do_op(8'hD9, 0, "R8");
        set_regs(19); do_op(8'hF2, 0, "R8");
        // R10: wrap at the top and a negative index step
        set_regs(20); ptr[2] = 16'hFFFF; do_op(8'h22, 0, "R10");
        set_regs(21); ptr[1] = 16'h0001; idx[1] = 16'hFFFE; do_op(8'h45, 0, "R10");
        // R9: long epilogue delay
        set_regs(22); do_op(8'h6B, 6, "R9");

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule